// File: doc/BRIEF.md
# Double-Data-Rate ADC Lane Formatter

This block sits between a source-synchronous parallel converter bus and a capture buffer that accepts four 16-bit sample lanes on one common clock. It runs on a clock that has one cycle for each level of the converter's data-ready strobe. Each cycle it samples the data bus (channel A), a second data bus (channel B, used only by dual-channel converters) and the strobe level. It then steers the samples onto fixed lanes according to a format mode. The mode selects double-data-rate single channel, single-rate single channel, single-rate dual channel, or off.

In double-data-rate format the strobe-high sample and the strobe-low sample that follows it leave together, on lanes 0 and 1, once per strobe period. The lane that each strobe phase lands on never changes. Single-rate converters use lane 2, and a dual-channel part also uses lane 3. Every sample is justified before it leaves. The raw word is shifted down by a bottom-offset setting, and the result is sign-extended from a valid-bit width. This handles a narrow converter that sits in the middle of a wider board layout.

Top module: `lane_fmt_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four lane data outputs are zero and all four lane valid flags are low.
- R2: In double-data-rate mode (fmtMode = 0), when a strobe-low cycle directly follows a strobe-high cycle, the next clock presents the justified sample from that strobe-high cycle on lane 0. On the same clock, lane 1 shows the justified sample from the strobe-low cycle, and valid flags 0 and 1 are both high. If the strobe stays high for several cycles, the last of those high samples is the one used.
- R3: Valid flags 0 and 1 are always equal, and they are never high on two consecutive clocks.
- R4: The edge-select input (edgeSelFall) has no effect on any output in double-data-rate mode.
- R5: In single-rate single-channel mode (fmtMode = 1), a cycle counts as a capture cycle when the strobe rises if edgeSelFall = 0, and when it falls if edgeSelFall = 1. "Rises" means strobe is 1 and it was 0 in the previous cycle; "falls" means the reverse. On the next clock after a capture cycle, lane 2 shows the justified channel A sample and valid flag 2 is high.
- R6: In single-rate dual-channel mode (fmtMode = 2), the capture cycle follows the rule of R5. Lane 2 takes justified channel A and lane 3 takes justified channel B, and valid flags 2 and 3 rise together.
- R7: Lanes that the current mode does not use output zero with their valid flag low. Lanes 2 and 3 are unused in mode 0, lanes 0, 1 and 3 in mode 1, lanes 0 and 1 in mode 2, and all four lanes in mode 3.
- R8: A justified sample is the raw word shifted right by bitOffset with zero fill. Bits below position validBits are kept, and every bit at or above it is a copy of bit validBits-1. A validBits value of 0 or above 16 means the full 16 bits are kept. For example, a raw word of 0x2004 with validBits = 12 and bitOffset = 2 gives 0xF801.
- R9: A used lane keeps its last data value on clocks where its valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle for each strobe level |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtMode | input | 2 | Format mode: 0 double-data-rate, 1 single-rate single channel, 2 single-rate dual channel, 3 off |
| edgeSelFall | input | 1 | Single-rate capture on falling strobe when 1, rising strobe when 0 |
| validBits | input | 5 | Count of valid data bits above the offset (0 means 16) |
| bitOffset | input | 4 | Count of low raw bits to discard |
| strobe | input | 1 | Data-ready strobe level for this cycle |
| chanA | input | 16 | Raw word, channel A |
| chanB | input | 16 | Raw word, channel B |
| lane0Data | output | 16 | Lane 0 sample (strobe-high phase) |
| lane1Data | output | 16 | Lane 1 sample (strobe-low phase) |
| lane2Data | output | 16 | Lane 2 sample (single-rate channel A) |
| lane3Data | output | 16 | Lane 3 sample (single-rate channel B) |
| laneValid | output | 4 | Per-lane valid flags, bit n for lane n |

## Verification
Two kinds of internal fault show up at the ports. If the previous-strobe register is wrong, the valid flags fire on the wrong phase or twice in a row. That appears on the clock after the bad strobe cycle. If the held strobe-high sample is stale or missing, lane 0 carries a value from an older period while lane 1 is correct. That also shows on the first pair emitted afterwards. Justification faults corrupt every sample at once, which random widths and offsets expose within a few captures. Changing the mode must zero the unused lanes on the next clock, so a lane left enabled by mistake is seen at once.

// File: rtl/lane_fmt_pkg.sv
package lane_fmt_pkg;

  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    FMT_DDR  = 2'd0,
    FMT_SDR1 = 2'd1,
    FMT_SDR2 = 2'd2,
    FMT_OFF  = 2'd3
  } fmt_e;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic                 holdHi;    // latch channel A as the strobe-high sample
    logic                 emitPair;  // present lanes 0/1 this clock
    logic                 emitSdr;   // present single-rate lanes this clock
    logic [NUM_LANES-1:0] laneEn;    // lanes used by the current mode
  } lane_ctl_t;

endpackage

// File: rtl/lane_fmt_justify.sv
module lane_fmt_justify #(
  parameter int SAMPLE_W = 16,
  parameter int VB_W     = $clog2(SAMPLE_W) + 1,
  parameter int OFF_W    = $clog2(SAMPLE_W)
) (
  input  logic [SAMPLE_W-1:0] rawWord,
  input  logic [VB_W-1:0]     validBits,
  input  logic [OFF_W-1:0]    bitOffset,
  output logic [SAMPLE_W-1:0] sample
);

  logic [SAMPLE_W-1:0] shifted;
  logic                signBit;
  int                  keepBits;

  always_comb begin
    shifted = rawWord >> bitOffset;
    if (validBits == '0 || int'(validBits) > SAMPLE_W) keepBits = SAMPLE_W;
    else                                                keepBits = int'(validBits);
    signBit = shifted[keepBits-1];
  end

  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++) begin
      sample[i] = (i < keepBits) ? shifted[i] : signBit;
    end
  end

endmodule

// File: rtl/lane_fmt_ctrl.sv
module lane_fmt_ctrl
  import lane_fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] fmtMode,
  input  logic      edgeSelFall,
  input  logic      strobe,
  output lane_ctl_t ctl
);

  logic strbPrev;
  logic riseSeen;
  logic fallSeen;
  logic sdrCapture;
  fmt_e fmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strbPrev <= 1'b0;
    else       strbPrev <= strobe;
  end

  always_comb begin
    fmt        = fmt_e'(fmtMode);
    riseSeen   = strobe && !strbPrev;
    fallSeen   = !strobe && strbPrev;
    sdrCapture = edgeSelFall ? fallSeen : riseSeen;

    ctl = '0;
    unique case (fmt)
      FMT_DDR: begin
        ctl.laneEn   = 4'b0011;
        ctl.holdHi   = strobe;
        ctl.emitPair = fallSeen;   // edge select deliberately unused here
      end
      FMT_SDR1: begin
        ctl.laneEn  = 4'b0100;
        ctl.emitSdr = sdrCapture;
      end
      FMT_SDR2: begin
        ctl.laneEn  = 4'b1100;
        ctl.emitSdr = sdrCapture;
      end
      default: ctl.laneEn = 4'b0000;
    endcase
  end

endmodule

// File: rtl/lane_fmt_dp.sv
module lane_fmt_dp
  import lane_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int VB_W     = $clog2(SAMPLE_W) + 1,
  parameter int OFF_W    = $clog2(SAMPLE_W)
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  lane_ctl_t                             ctl,
  input  logic [VB_W-1:0]                       validBits,
  input  logic [OFF_W-1:0]                      bitOffset,
  input  logic [SAMPLE_W-1:0]                   chanA,
  input  logic [SAMPLE_W-1:0]                   chanB,
  output logic [NUM_LANES-1:0][SAMPLE_W-1:0]    laneData,
  output logic [NUM_LANES-1:0]                  laneValid
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0][SAMPLE_W-1:0] rawCh;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] justCh;
  logic [SAMPLE_W-1:0]             hiHold;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] laneNext;
  logic [NUM_LANES-1:0]            laneLoad;

  assign rawCh[0] = chanA;
  assign rawCh[1] = chanB;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_just
    lane_fmt_justify #(
      .SAMPLE_W(SAMPLE_W), .VB_W(VB_W), .OFF_W(OFF_W)
    ) just_i (
      .rawWord  (rawCh[c]),
      .validBits(validBits),
      .bitOffset(bitOffset),
      .sample   (justCh[c])
    );
  end

  // Strobe-high sample waits here for its strobe-low partner
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hiHold <= '0;
    else if (ctl.holdHi) hiHold <= justCh[0];
  end

  always_comb begin
    laneNext[0] = hiHold;
    laneNext[1] = justCh[0];
    laneNext[2] = justCh[0];
    laneNext[3] = justCh[1];
    laneLoad[0] = ctl.emitPair;
    laneLoad[1] = ctl.emitPair;
    laneLoad[2] = ctl.emitSdr;
    laneLoad[3] = ctl.emitSdr;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneData[l]  <= '0;
        laneValid[l] <= 1'b0;
      end else if (!ctl.laneEn[l]) begin
        laneData[l]  <= '0;
        laneValid[l] <= 1'b0;
      end else begin
        laneValid[l] <= laneLoad[l];
        if (laneLoad[l]) laneData[l] <= laneNext[l];
      end
    end
  end

endmodule

// File: rtl/lane_fmt_top.sv
module lane_fmt_top
  import lane_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int VB_W     = $clog2(SAMPLE_W) + 1,
  parameter int OFF_W    = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          fmtMode,
  input  logic                edgeSelFall,
  input  logic [VB_W-1:0]     validBits,
  input  logic [OFF_W-1:0]    bitOffset,
  input  logic                strobe,
  input  logic [SAMPLE_W-1:0] chanA,
  input  logic [SAMPLE_W-1:0] chanB,
  output logic [SAMPLE_W-1:0] lane0Data,
  output logic [SAMPLE_W-1:0] lane1Data,
  output logic [SAMPLE_W-1:0] lane2Data,
  output logic [SAMPLE_W-1:0] lane3Data,
  output logic [NUM_LANES-1:0] laneValid
);

  lane_ctl_t                          ctl;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] laneData;

  lane_fmt_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .fmtMode    (fmtMode),
    .edgeSelFall(edgeSelFall),
    .strobe     (strobe),
    .ctl        (ctl)
  );

  lane_fmt_dp #(
    .SAMPLE_W(SAMPLE_W), .VB_W(VB_W), .OFF_W(OFF_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .validBits(validBits),
    .bitOffset(bitOffset),
    .chanA    (chanA),
    .chanB    (chanB),
    .laneData (laneData),
    .laneValid(laneValid)
  );

  assign lane0Data = laneData[0];
  assign lane1Data = laneData[1];
  assign lane2Data = laneData[2];
  assign lane3Data = laneData[3];

endmodule

// File: rtl/lane_fmt_chk.sv
module lane_fmt_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          fmtMode,
  input logic                strobe,
  input logic [SAMPLE_W-1:0] lane2Data,
  input logic [SAMPLE_W-1:0] lane3Data,
  input logic [3:0]          laneValid
);

  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= 2'd0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  // R3
  pair_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneValid[0] == laneValid[1]);

  // R3
  pair_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneValid[0] |=> !laneValid[0]);

  // R2
  pair_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2 && laneValid[0]) |->
      (!$past(strobe) && $past(strobe, 2) && $past(fmtMode) == 2'd0));

  // R7
  ddr_idle_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && $past(fmtMode) == 2'd0) |->
      (laneValid[3:2] == 2'b00 && lane2Data == '0 && lane3Data == '0));

  // R6
  dual_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneValid[3] |-> laneValid[2]);

  // R7
  off_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && $past(fmtMode) == 2'd3) |-> laneValid == 4'b0000);

endmodule

bind lane_fmt_top lane_fmt_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .fmtMode  (fmtMode),
  .strobe   (strobe),
  .lane2Data(lane2Data),
  .lane3Data(lane3Data),
  .laneValid(laneValid)
);

// File: tb/lane_fmt_top_tb_top.sv
`timescale 1ns/1ps
module lane_fmt_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  fmtMode;
  logic        edgeSelFall;
  logic [4:0]  validBits;
  logic [3:0]  bitOffset;
  logic        strobe;
  logic [15:0] chanA, chanB;
  logic [15:0] lane0Data, lane1Data, lane2Data, lane3Data;
  logic [3:0]  laneValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  logic        mPrev;
  logic [15:0] mHi;
  logic [15:0] mLane [4];
  logic [3:0]  mVld;

  always #2.5 clk = ~clk;

  lane_fmt_top dut_i (
    .clk(clk), .rstN(rstN), .fmtMode(fmtMode), .edgeSelFall(edgeSelFall),
    .validBits(validBits), .bitOffset(bitOffset), .strobe(strobe),
    .chanA(chanA), .chanB(chanB),
    .lane0Data(lane0Data), .lane1Data(lane1Data),
    .lane2Data(lane2Data), .lane3Data(lane3Data), .laneValid(laneValid)
  );

  // R8 justification rule
  function automatic logic [15:0] justify(logic [15:0] raw, logic [4:0] vb, logic [3:0] off);
    logic [15:0] s;
    logic [15:0] r;
    int n;
    s = raw >> off;
    n = (vb == 0 || vb > 16) ? 16 : int'(vb);
    for (int i = 0; i < 16; i++) r[i] = (i < n) ? s[i] : s[n-1];
    return r;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mPrev = 0; mHi = '0; mVld = '0;
    for (int l = 0; l < 4; l++) mLane[l] = '0;
  endtask

  // model one clock using the inputs present at the edge
  task automatic modelStep();
    logic [15:0] ja, jb;
    logic        cap;
    ja = justify(chanA, validBits, bitOffset);
    jb = justify(chanB, validBits, bitOffset);
    mVld = '0;
    case (fmtMode)
      2'd0: begin
        mLane[2] = '0; mLane[3] = '0;
        if (!strobe && mPrev) begin
          mLane[0] = mHi; mLane[1] = ja; mVld[1:0] = 2'b11;
        end
        if (strobe) mHi = ja;
      end
      2'd1, 2'd2: begin
        mLane[0] = '0; mLane[1] = '0;
        cap = edgeSelFall ? (!strobe && mPrev) : (strobe && !mPrev);
        if (cap) begin mLane[2] = ja; mVld[2] = 1'b1; end
        if (fmtMode == 2'd2) begin
          if (cap) begin mLane[3] = jb; mVld[3] = 1'b1; end
        end else mLane[3] = '0;
      end
      default: for (int l = 0; l < 4; l++) mLane[l] = '0;
    endcase
    mPrev = strobe;
  endtask

  task automatic compareAll();
    string t01, t23;
    t01 = (fmtMode == 2'd0) ? (edgeSelFall ? "R4" : "R2") : "R7";
    t23 = (fmtMode == 2'd1) ? "R5" : (fmtMode == 2'd2) ? "R6" : "R7";
    chk({t01, " lane0"}, lane0Data, mLane[0]);
    chk({t01, " lane1"}, lane1Data, mLane[1]);
    chk({t23, " lane2"}, lane2Data, mLane[2]);
    chk({t23 == "R5" ? "R7" : t23, " lane3"}, lane3Data, mLane[3]);
    chk("R3 valid flags", {12'd0, laneValid}, {12'd0, mVld});
  endtask

  task automatic step(logic s, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    strobe = s; chanA = a; chanB = b;
    @(posedge clk);
    #1;
    modelStep();
    compareAll();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 0; fmtMode = 0; edgeSelFall = 0; validBits = 0; bitOffset = 0;
    strobe = 0; chanA = '0; chanB = '0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 lane0", lane0Data, 16'h0);
    chk("R1 lane3", lane3Data, 16'h0);
    chk("R1 valid", {12'd0, laneValid}, 16'h0);
    @(negedge clk); rstN = 1;

    // R8 directed: 12 bits, offset 2, single-rate single channel
    fmtMode = 2'd1; validBits = 5'd12; bitOffset = 4'd2;
    step(0, 16'h0, 16'h0);
    step(1, 16'h2004, 16'h0);
    chk("R8 negative mid-word", lane2Data, 16'hF801);
    step(0, 16'h0, 16'h0);
    chk("R9 hold lane2", lane2Data, 16'hF801);
    step(1, 16'hC006, 16'h0);
    chk("R8 positive mid-word", lane2Data, 16'h0001);
    validBits = 5'd0; bitOffset = 4'd0;
    step(0, 16'h0, 16'h0);
    step(1, 16'h8001, 16'h0);
    chk("R8 full width", lane2Data, 16'h8001);

    // R2 directed DDR pair
    fmtMode = 2'd0; validBits = 5'd12; bitOffset = 4'd2;
    step(1, 16'h0044, 16'h0);
    step(0, 16'h2004, 16'h0);
    chk("R2 lane0 high phase", lane0Data, 16'h0011);
    chk("R2 lane1 low phase", lane1Data, 16'hF801);
    chk("R2 pair valid", {12'd0, laneValid}, 16'h0003);

    // random mix
    for (int blk = 0; blk < 40; blk++) begin
      fmtMode     = 2'($urandom_range(0, 3));
      edgeSelFall = 1'($urandom);
      validBits   = 5'($urandom_range(0, 20));
      bitOffset   = 4'($urandom);
      for (int c = 0; c < 60; c++) begin
        logic s;
        if (fmtMode == 2'd0) s = ($urandom_range(0, 7) == 0) ? strobe : ~strobe;
        else                 s = 1'($urandom);
        step(s, 16'($urandom), 16'($urandom));
      end
      if (blk == 20) begin
        @(negedge clk); rstN = 0; #1;
        modelReset();
        chk("R1 mid-run reset", {12'd0, laneValid}, 16'h0);
        chk("R1 mid-run lane1", lane1Data, 16'h0);
        @(negedge clk); rstN = 1;
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule